// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures the frequency of a free-running on-chip oscillator against the reference clock that it runs on. Software programs a window length N, expressed in oscillator cycles, and turns on the free-run clock gate. It then raises the enable bit. The block brings the oscillator into the reference domain through a two-flop synchroniser followed by a rising-edge detector. It waits for the first oscillator edge and counts reference cycles until N further oscillator edges have been seen. When the window closes, the block sets a sticky valid flag.

The measurement therefore reports how many reference cycles fit into N oscillator periods. A slow oscillator produces a large count. Software computes the frequency as N times the reference frequency, divided by the count. A count of zero means the measurement failed. This happens when the window is zero or when the oscillator never toggles. The result stays readable until the next measurement starts.

The oscillator must stay high and low for at least two reference cycles each, so that the synchroniser catches every edge.

Top module: `rosc_freq_meter`

## Requirements
- R1: After the synchronous reset, the control, status and result registers all read as zero.
- R2: The register map is as follows. The control register sits at offset 0x00, with the window length N in bits 23:0 and the meter enable in bit 24. The status register sits at 0x10, with the free-run clock enable (read/write) in bit 8 and the valid flag (read-only) in bit 0. The result register sits at 0x0C. Read data is registered and appears one cycle after the address. Unmapped offsets read as zero.
- R3: A measurement starts when the meter enable goes from 0 to 1 while the free-run enable is set. The result is then the number of reference cycles from the first detected oscillator rising edge to the N-th rising edge after it. For an oscillator with a period of exactly P reference cycles, this equals N*P.
- R4: The valid flag is set when the window completes. While valid stays set, the result does not change.
- R5: Clearing the meter enable clears the valid flag on the next cycle. The result register keeps its last value until a new measurement starts.
- R6: If the meter enable rises while the free-run enable is clear, no measurement takes place. Valid stays low, even if the free-run enable is set later, until the meter enable rises again.
- R7: A window length of zero completes immediately, with valid set and a result of zero.
- R8: The result counter saturates at all-ones and never wraps.
- R9: Writes to the result register and to the valid bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_clk | input | 1 | Oscillator under measurement, asynchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |

## Verification
The oscillator in the bench is derived from the reference clock, so every expected count is exactly N*P and carries no phase uncertainty. Several defects would show up as an off-by-one in the result, visible as soon as valid rises: a window counter stuck or off by one, an edge counted twice, or a result counter that starts late. A broken start qualifier would show within a few hundred cycles, either as a spurious valid or as a missing one. A wrap instead of saturation would show as a small result in the long-window case. Holding and clearing behaviour is checked by re-reading the status and result registers after disable and after writes that must be ignored.

// File: rtl/rosc_fm_pkg.sv
package rosc_fm_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RESULT = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam int         STS_FRCK_BIT  = 8;
  localparam int         STS_VALID_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } fm_state_t;
endpackage

// File: rtl/rosc_fm_edge_sync.sv
module rosc_fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], async_in};
  end

  // stage STAGES-1 is the last synchroniser flop, stage STAGES its delayed copy
  always_ff @(posedge clk) begin
    if (rst) rise <= 1'b0;
    else     rise <= shreg[STAGES-1] & ~shreg[STAGES];
  end
endmodule

// File: rtl/rosc_fm_regs.sv
module rosc_fm_regs
  import rosc_fm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              valid,
  input  logic [RES_W-1:0]  result,
  output logic [CNT_W-1:0]  win_len,
  output logic              meter_en,
  output logic              meter_en_rise,
  output logic              frck_en
);
  localparam int EN_BIT = CNT_W;

  logic meter_en_d;
  logic [31:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_len    <= '0;
      meter_en   <= 1'b0;
      meter_en_d <= 1'b0;
      frck_en    <= 1'b0;
    end else begin
      meter_en_d <= meter_en;
      if (reg_we && reg_addr == ADDR_W'(OFS_CTRL)) begin
        win_len  <= reg_wdata[CNT_W-1:0];
        meter_en <= reg_wdata[EN_BIT];
      end
      if (reg_we && reg_addr == ADDR_W'(OFS_STATUS))
        frck_en <= reg_wdata[STS_FRCK_BIT];
    end
  end

  assign meter_en_rise = meter_en & ~meter_en_d;

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL)) begin
      rd_next[CNT_W-1:0] = win_len;
      rd_next[EN_BIT]    = meter_en;
    end else if (reg_addr == ADDR_W'(OFS_STATUS)) begin
      rd_next[STS_FRCK_BIT]  = frck_en;
      rd_next[STS_VALID_BIT] = valid;
    end else if (reg_addr == ADDR_W'(OFS_RESULT)) begin
      rd_next[RES_W-1:0] = result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/rosc_fm_core.sv
module rosc_fm_core
  import rosc_fm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meter_en,
  input  logic             start,
  input  logic [CNT_W-1:0] win_len,
  input  logic             osc_rise,
  output logic             valid,
  output logic             busy,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] RES_MAX = '1;

  fm_state_t        state;
  logic [CNT_W-1:0] win_cnt;
  logic             last_edge;

  assign last_edge = ({1'b0, win_cnt} + 1'b1) == {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      result  <= '0;
    end else if (!meter_en) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          result  <= '0;
          win_cnt <= '0;
          state   <= (win_len == '0) ? ST_DONE : ST_ARM;
        end
        ST_ARM: if (osc_rise) state <= ST_RUN;
        ST_RUN: begin
          if (result != RES_MAX) result <= result + 1'b1;
          if (osc_rise) begin
            if (last_edge) state <= ST_DONE;
            else           win_cnt <= win_cnt + 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign valid = (state == ST_DONE);
  assign busy  = (state == ST_ARM) || (state == ST_RUN);
endmodule

// File: rtl/rosc_freq_meter.sv
module rosc_freq_meter #(
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 24,
  parameter int RES_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_clk,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic [CNT_W-1:0] win_len;
  logic             meter_en;
  logic             meter_en_rise;
  logic             frck_en;
  logic             osc_rise;
  logic             start;
  logic             valid;
  logic             busy;
  logic [RES_W-1:0] result;

  assign start = meter_en_rise & frck_en;

  rosc_fm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .valid(valid),
    .result(result), .win_len(win_len), .meter_en(meter_en),
    .meter_en_rise(meter_en_rise), .frck_en(frck_en)
  );

  rosc_fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(meas_clk), .rise(osc_rise)
  );

  rosc_fm_core #(.CNT_W(CNT_W), .RES_W(RES_W)) u_core (
    .clk(clk), .rst(rst), .meter_en(meter_en), .start(start),
    .win_len(win_len), .osc_rise(osc_rise), .valid(valid),
    .busy(busy), .result(result)
  );
endmodule

// File: rtl/rosc_freq_meter_chk.sv
module rosc_freq_meter_chk #(
  parameter int CNT_W = 24,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             meter_en,
  input logic             meter_en_rise,
  input logic             frck_en,
  input logic [CNT_W-1:0] win_len,
  input logic             valid,
  input logic             busy,
  input logic [RES_W-1:0] result
);
  AST_NO_START_WITHOUT_FRCK: assert property (@(posedge clk) disable iff (rst)
    (meter_en_rise && !frck_en) |=> (!busy && !valid)); // R6

  AST_ZERO_WINDOW_DONE: assert property (@(posedge clk) disable iff (rst)
    (meter_en_rise && frck_en && win_len == '0) |=> (valid && result == '0)); // R7

  AST_DISABLE_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    (!meter_en) |=> !valid); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> $stable(result)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (result >= $past(result))); // R8
endmodule

bind rosc_freq_meter rosc_freq_meter_chk #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .meter_en(meter_en), .meter_en_rise(meter_en_rise),
  .frck_en(frck_en), .win_len(win_len), .valid(valid), .busy(busy),
  .result(result)
);

// File: tb/test_rosc_freq_meter.sv
`timescale 1ns/1ps
module test_rosc_freq_meter;
  localparam int ADDR_W = 8;
  localparam int RES_W  = 10;
  localparam int SAT    = (1 << RES_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic meas_clk = 1'b0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int osc_p   = 4;
  int ph      = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  int unsigned exp_q[$];
  int unsigned obs_val;
  string       obs_tag;
  event        obs_ev;

  always #5 clk = ~clk;

  rosc_freq_meter #(.ADDR_W(ADDR_W), .RES_W(RES_W)) i_rosc_freq_meter (
    .clk(clk), .rst(rst), .meas_clk(meas_clk), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // oscillator model: period of exactly osc_p reference cycles
  always @(negedge clk) begin
    ph       <= (ph + 1 >= osc_p) ? 0 : ph + 1;
    meas_clk <= (ph < osc_p / 2);
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(obs_ev) begin
    if (exp_q.size() == 0) check({obs_tag, " (no expected item)"}, obs_val, 32'hDEAD);
    else check(obs_tag, obs_val, exp_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: runs a measurement, pushes the expected result, hands the observed one over
  task automatic measure(input int n, input int p, input string tag);
    logic [31:0] d;
    bit got;
    int unsigned e;
    osc_p = p;
    e = (n * p > SAT) ? SAT : n * p;
    exp_q.push_back(e);
    wr(8'h00, 32'(n));
    wr(8'h00, 32'(n) | 32'h0100_0000);
    got = 1'b0;
    for (int i = 0; i < 4000 && !got; i++) begin
      rd(8'h10, d);
      got = d[0];
    end
    check({tag, " valid seen"}, 32'(got), 32'd1);
    rd(8'h0C, d);
    obs_val = d; obs_tag = tag;
    -> obs_ev;
    #1;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(8'h00, d); check("R1 ctrl after reset", d, 0);
    rd(8'h10, d); check("R1 status after reset", d, 0);
    rd(8'h0C, d); check("R1 result after reset", d, 0);
    // R2 register readback and unmapped offset
    wr(8'h00, 32'h00AB_CDEF);
    rd(8'h00, d); check("R2 ctrl readback", d, 32'h00AB_CDEF);
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, d); check("R2 status free-run bit", d, 32'h100);
    rd(8'h04, d); check("R2 unmapped reads zero", d, 0);
    // R3 main function, several windows and periods
    measure(16, 4, "R3 N=16 P=4");
    wr(8'h00, 32'd0);
    measure(1, 5, "R3 N=1 P=5");
    wr(8'h00, 32'd0);
    measure(10, 7, "R3 N=10 P=7");
    // R4 hold while valid
    idle(60);
    rd(8'h0C, d); check("R4 result held", d, 70);
    rd(8'h10, d); check("R4 valid held", d, 32'h101);
    // R9 ignored writes
    wr(8'h0C, 32'h0000_0155);
    rd(8'h0C, d); check("R9 result write ignored", d, 70);
    // R5 disable clears valid, keeps result
    wr(8'h00, 32'd10);
    rd(8'h10, d); check("R5 valid cleared", d, 32'h100);
    rd(8'h0C, d); check("R5 result kept", d, 70);
    wr(8'h10, 32'h0000_0101);
    rd(8'h10, d); check("R9 valid bit not writable", d, 32'h100);
    // R6 no start without free-run enable
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h0100_0008);
    idle(100);
    rd(8'h10, d); check("R6 no valid without free-run", d, 0);
    wr(8'h10, 32'h100);
    idle(100);
    rd(8'h10, d); check("R6 late free-run does not start", d, 32'h100);
    rd(8'h0C, d); check("R6 result untouched", d, 70);
    wr(8'h00, 32'd0);
    // R7 zero window
    measure(0, 4, "R7 zero window");
    wr(8'h00, 32'd0);
    // R8 saturation
    measure(300, 4, "R8 saturation");
    wr(8'h00, 32'd0);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    wait (done || cycles >= 150000);
    if (!done) check("watchdog", 32'(cycles), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule